// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host processor move data in and out of the adapter's local packet RAM through one data port, without mapping that RAM into the host's address space. The host programs a 16-bit pointer and a 16-bit byte count through byte-wide register writes. Each access to the data port then transfers either one byte or one little-endian 16-bit word, as chosen by a configuration bit. After each access the pointer advances and the count shrinks. The pointer folds back to the ring start page when it reaches the ring stop page.

The block also holds the command register, the interrupt status and mask registers, and the interrupt line. A command register field selects a register page. The receive path is outside this block and appears only as a request to set status bits 0 to 5. Local RAM is an external synchronous 16-bit memory with byte enables and one cycle of read latency. Only the address PROM window and the packet-memory window are legal. Reads elsewhere return ones, and writes elsewhere go nowhere.

Top module: `rdma_port_engine`

## Requirements
- R1: Out of reset the command register reads 0x01, the status register reads 0x80, the mask, pointer and count read 0, and irq_o is low.
- R2: While page 0 is selected, register offsets 8 and 9 load the low and high byte of the pointer, and offsets 10 and 11 load the low and high byte of the count. Each byte loads through a separate write, and all four read back at the same offsets.
- R3: When configuration bit 0 (offset 14) is clear, a data-port write (bus address 0x10) stores bus_wdata_i[7:0] at the pointer. The pointer then advances by 1 and the count drops by 1.
- R4: When configuration bit 0 is set, a data-port access moves one 16-bit word at the pointer with bit 0 forced to zero. The even byte maps to data bits [7:0]. The pointer then advances by 2 from its unforced value and the count drops by 2.
- R5: If the advanced pointer equals the stop page times 256, it is reloaded with the start page times 256. The start page is at offset 1 and the stop page at offset 2.
- R6: If the count before an access is at most the transfer size, the count becomes 0 and status bit 6 (transfer complete) is set.
- R7: A data-port write while the count is 0 leaves the RAM, the pointer and the count unchanged.
- R8: Legal local memory is bytes 0 to 31 and 16384 to 49151. Reads elsewhere return 0x00FF in byte mode and 0xFFFF in word mode, and writes elsewhere issue no RAM write.
- R9: A data-port read returns the byte (zero-extended) or the word at the current pointer in the same cycle, provided the pointer has been unchanged for one full cycle. The read then advances the pointer and the count as in R3 to R6.
- R10: A command write with bit 0 clear clears status bit 7. If that write also has bit 3 or bit 4 set while the count is 0, it sets status bit 6. A command write with bit 0 set does neither. Bit 7 is never set again after reset.
- R11: irq_o is high exactly when status AND mask AND 0x7F is nonzero. Status bit 7 never raises irq_o.
- R12: Writing the status register (offset 7, page 0) clears each of bits 0 to 6 that is written as 1 and never touches bit 7. rx_set_i sets status bits 0 to 5, and a set wins over a clear in the same cycle.
- R13: Command bits 7:6 select the register page. Writes to offsets 1 to 15 on any page other than 0 have no effect. Page 2 reads return the start page at offset 1 and the stop page at offset 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 5 | Host address: 0x00-0x0F registers, 0x10 data port |
| bus_wr_i | input | 1 | Host write strobe, one cycle per access |
| bus_rd_i | input | 1 | Host read strobe, one cycle per access |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Host read data, valid in the strobe cycle |
| rx_set_i | input | 6 | Receive-side requests to set status bits 0-5 |
| irq_o | output | 1 | Host interrupt line |
| ram_addr_o | output | 15 | Local RAM word address |
| ram_we_o | output | 1 | Local RAM write enable |
| ram_be_o | output | 2 | Local RAM byte-lane enables |
| ram_wdata_o | output | 16 | Local RAM write data |
| ram_rdata_i | input | 16 | Local RAM read data, one cycle after the address |

## Verification
Register writes, pointer and count updates, and status changes commit at the clock edge that ends the strobe cycle. Readback and irq_o are combinational, so they reflect the change from the next cycle onward. Data-port read data depends on the RAM having registered the pointer, so it is correct from the second cycle after any access that moves the pointer. Each bench operation therefore drives its strobe for one cycle and then leaves one idle cycle before the next operation. The monitor compares read data and irq_o 1 ns after each falling edge, while the strobe being checked is still applied.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int unsigned RDMA_ADDR_W = 16;

  localparam logic [3:0] OFF_CMD   = 4'h0;
  localparam logic [3:0] OFF_START = 4'h1;
  localparam logic [3:0] OFF_STOP  = 4'h2;
  localparam logic [3:0] OFF_STAT  = 4'h7;
  localparam logic [3:0] OFF_ALO   = 4'h8;
  localparam logic [3:0] OFF_AHI   = 4'h9;
  localparam logic [3:0] OFF_CLO   = 4'hA;
  localparam logic [3:0] OFF_CHI   = 4'hB;
  localparam logic [3:0] OFF_CFG   = 4'hE;
  localparam logic [3:0] OFF_MASK  = 4'hF;

  localparam int unsigned CMD_HALT = 0;
  localparam int unsigned CMD_RRD  = 3;
  localparam int unsigned CMD_RWR  = 4;
  localparam int unsigned ST_DONE  = 6;
  localparam int unsigned ST_RST   = 7;

  typedef enum logic [1:0] {PG_0 = 2'd0, PG_1 = 2'd1, PG_2 = 2'd2, PG_3 = 2'd3} page_e;
endpackage

// File: rtl/rdma_host_regs.sv
module rdma_host_regs
  import rdma_pkg::*;
#(
  parameter int unsigned ADDR_W = RDMA_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        off_i,
  input  logic [7:0]        wdata_i,
  input  logic [5:0]        rx_set_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cnt_i,
  output logic [7:0]        rdata_o,
  output logic              ld_alo_o,
  output logic              ld_ahi_o,
  output logic              ld_clo_o,
  output logic              ld_chi_o,
  output logic [7:0]        start_pg_o,
  output logic [7:0]        stop_pg_o,
  output logic              wide_o,
  output logic              irq_o
);
  logic [7:0] cmd_q, start_q, stop_q, cfg_q, mask_q, status_q, status_d;
  page_e page;
  logic wr_cmd, wr_pg0, go, dma_cmd, cnt_zero;

  assign page     = page_e'(cmd_q[7:6]);
  assign wr_cmd   = wr_i && (off_i == OFF_CMD);
  assign wr_pg0   = wr_i && (off_i != OFF_CMD) && (page == PG_0);
  assign go       = wr_cmd && !wdata_i[CMD_HALT];
  assign dma_cmd  = wdata_i[CMD_RRD] | wdata_i[CMD_RWR];
  assign cnt_zero = (cnt_i == '0);

  assign ld_alo_o = wr_pg0 && (off_i == OFF_ALO);
  assign ld_ahi_o = wr_pg0 && (off_i == OFF_AHI);
  assign ld_clo_o = wr_pg0 && (off_i == OFF_CLO);
  assign ld_chi_o = wr_pg0 && (off_i == OFF_CHI);

  always_comb begin
    status_d = status_q;
    if (wr_pg0 && (off_i == OFF_STAT)) status_d[6:0] = status_q[6:0] & ~wdata_i[6:0];
    if (go) status_d[ST_RST] = 1'b0;
    if (go && dma_cmd && cnt_zero) status_d[ST_DONE] = 1'b1;
    if (done_i) status_d[ST_DONE] = 1'b1;
    status_d[5:0] = status_d[5:0] | rx_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= 8'h01;
      start_q  <= '0;
      stop_q   <= '0;
      cfg_q    <= '0;
      mask_q   <= '0;
      status_q <= 8'h80;
    end else begin
      status_q <= status_d;
      if (wr_cmd) cmd_q <= wdata_i;
      if (wr_pg0) begin
        case (off_i)
          OFF_START: start_q <= wdata_i;
          OFF_STOP:  stop_q  <= wdata_i;
          OFF_CFG:   cfg_q   <= wdata_i;
          OFF_MASK:  mask_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (off_i == OFF_CMD) begin
      rdata_o = cmd_q;
    end else if (page == PG_0) begin
      case (off_i)
        OFF_STAT: rdata_o = status_q;
        OFF_ALO:  rdata_o = addr_i[7:0];
        OFF_AHI:  rdata_o = addr_i[ADDR_W-1 -: 8];
        OFF_CLO:  rdata_o = cnt_i[7:0];
        OFF_CHI:  rdata_o = cnt_i[ADDR_W-1 -: 8];
        OFF_CFG:  rdata_o = cfg_q;
        OFF_MASK: rdata_o = mask_q;
        default:  rdata_o = '0;
      endcase
    end else if (page == PG_2) begin
      case (off_i)
        OFF_START: rdata_o = start_q;
        OFF_STOP:  rdata_o = stop_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign start_pg_o = start_q;
  assign stop_pg_o  = stop_q;
  assign wide_o     = cfg_q[0];
  assign irq_o      = |(status_q[6:0] & mask_q[6:0]);

  assert_irq_needs_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q[6:0] != 7'd0));

  assert_rst_flag_no_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(status_q[ST_RST]));

  assert_stat_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pg0 && off_i == OFF_STAT && rx_set_i == 6'd0 && !done_i)
      |=> ((status_q[6:0] & $past(wdata_i[6:0])) == 7'd0));
endmodule

// File: rtl/rdma_ptr_unit.sv
module rdma_ptr_unit
  import rdma_pkg::*;
#(
  parameter int unsigned ADDR_W = RDMA_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_alo_i,
  input  logic              ld_ahi_i,
  input  logic              ld_clo_i,
  input  logic              ld_chi_i,
  input  logic [7:0]        ld_byte_i,
  input  logic              step_i,
  input  logic              wide_i,
  input  logic [7:0]        start_pg_i,
  input  logic [7:0]        stop_pg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] cnt_o,
  output logic              done_o
);
  localparam int unsigned HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_q, cnt_q, sz, sum, nxt, start_a, stop_a;

  assign start_a = {HI_W'(start_pg_i), 8'h00};
  assign stop_a  = {HI_W'(stop_pg_i), 8'h00};
  assign sz      = wide_i ? ADDR_W'(2) : ADDR_W'(1);
  assign sum     = addr_q + sz;
  assign nxt     = (sum == stop_a) ? start_a : sum;
  assign done_o  = step_i && (cnt_q <= sz);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (step_i) begin
      addr_q <= nxt;
      cnt_q  <= done_o ? '0 : cnt_q - sz;
    end else begin
      if (ld_alo_i) addr_q[7:0]        <= ld_byte_i;
      if (ld_ahi_i) addr_q[ADDR_W-1:8] <= HI_W'(ld_byte_i);
      if (ld_clo_i) cnt_q[7:0]         <= ld_byte_i;
      if (ld_chi_i) cnt_q[ADDR_W-1:8]  <= HI_W'(ld_byte_i);
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

  assert_cnt_no_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_clo_i || ld_chi_i) |=> (cnt_q <= $past(cnt_q)));

  assert_done_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));

  assert_addr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !ld_alo_i && !ld_ahi_i) |=> $stable(addr_q));
endmodule

// File: rtl/rdma_mem_if.sv
module rdma_mem_if
  import rdma_pkg::*;
#(
  parameter int unsigned ADDR_W     = RDMA_ADDR_W,
  parameter int unsigned PROM_BYTES = 32,
  parameter int unsigned WIN_LO     = 16384,
  parameter int unsigned WIN_HI     = 49152
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  input  logic              wr_i,
  input  logic [15:0]       wdata_i,
  output logic [ADDR_W-2:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [1:0]        ram_be_o,
  output logic [15:0]       ram_wdata_o,
  input  logic [15:0]       ram_rdata_i,
  output logic [15:0]       rdata_o
);
  logic [ADDR_W-1:0] pf_addr_q;
  logic              legal_now, legal_pf;

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    int unsigned v;
    v = int'(a);
    return (v < PROM_BYTES) || ((v >= WIN_LO) && (v < WIN_HI));
  endfunction

  assign legal_now   = in_window(addr_i);
  assign ram_addr_o  = addr_i[ADDR_W-1:1];
  assign ram_we_o    = wr_i && legal_now;
  assign ram_be_o    = wide_i ? 2'b11 : (addr_i[0] ? 2'b10 : 2'b01);
  assign ram_wdata_o = wide_i ? wdata_i : {wdata_i[7:0], wdata_i[7:0]};

  // RAM output belongs to the pointer registered one cycle earlier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pf_addr_q <= '0;
    else         pf_addr_q <= addr_i;
  end

  assign legal_pf = in_window(pf_addr_q);

  always_comb begin
    if (!legal_pf)   rdata_o = wide_i ? 16'hFFFF : 16'h00FF;
    else if (wide_i) rdata_o = ram_rdata_i;
    else             rdata_o = {8'h00, pf_addr_q[0] ? ram_rdata_i[15:8] : ram_rdata_i[7:0]};
  end

  assert_we_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (({1'b0, ram_addr_o, 1'b0} < (ADDR_W+1)'(PROM_BYTES)) ||
                  (({1'b0, ram_addr_o, 1'b0} >= (ADDR_W+1)'(WIN_LO)) &&
                   ({1'b0, ram_addr_o, 1'b0} <  (ADDR_W+1)'(WIN_HI)))));

  assert_we_needs_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> wr_i);
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int unsigned ADDR_W     = RDMA_ADDR_W,
  parameter int unsigned PROM_BYTES = 32,
  parameter int unsigned WIN_LO     = 16384,
  parameter int unsigned WIN_HI     = 49152,
  parameter int unsigned BUS_AW     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  input  logic [5:0]        rx_set_i,
  output logic              irq_o,
  output logic [ADDR_W-2:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [1:0]        ram_be_o,
  output logic [15:0]       ram_wdata_o,
  input  logic [15:0]       ram_rdata_i
);
  localparam logic [BUS_AW-1:0] DP_ADDR = BUS_AW'(16);

  logic              dp_sel, reg_sel, dp_wr, dp_rd, step, done;
  logic              ld_alo, ld_ahi, ld_clo, ld_chi, wide;
  logic [7:0]        reg_rdata, start_pg, stop_pg;
  logic [15:0]       mem_rdata;
  logic [ADDR_W-1:0] addr, cnt;

  assign dp_sel  = (bus_addr_i == DP_ADDR);
  assign reg_sel = (bus_addr_i[BUS_AW-1:4] == '0);
  assign dp_wr   = dp_sel && bus_wr_i && (cnt != '0);
  assign dp_rd   = dp_sel && bus_rd_i && !bus_wr_i;
  assign step    = dp_wr || dp_rd;

  rdma_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_wr_i && reg_sel),
    .off_i      (bus_addr_i[3:0]),
    .wdata_i    (bus_wdata_i[7:0]),
    .rx_set_i   (rx_set_i),
    .done_i     (done),
    .addr_i     (addr),
    .cnt_i      (cnt),
    .rdata_o    (reg_rdata),
    .ld_alo_o   (ld_alo),
    .ld_ahi_o   (ld_ahi),
    .ld_clo_o   (ld_clo),
    .ld_chi_o   (ld_chi),
    .start_pg_o (start_pg),
    .stop_pg_o  (stop_pg),
    .wide_o     (wide),
    .irq_o      (irq_o)
  );

  rdma_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_alo_i   (ld_alo),
    .ld_ahi_i   (ld_ahi),
    .ld_clo_i   (ld_clo),
    .ld_chi_i   (ld_chi),
    .ld_byte_i  (bus_wdata_i[7:0]),
    .step_i     (step),
    .wide_i     (wide),
    .start_pg_i (start_pg),
    .stop_pg_i  (stop_pg),
    .addr_o     (addr),
    .cnt_o      (cnt),
    .done_o     (done)
  );

  rdma_mem_if #(
    .ADDR_W     (ADDR_W),
    .PROM_BYTES (PROM_BYTES),
    .WIN_LO     (WIN_LO),
    .WIN_HI     (WIN_HI)
  ) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr),
    .wide_i      (wide),
    .wr_i        (dp_wr),
    .wdata_i     (bus_wdata_i),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_be_o    (ram_be_o),
    .ram_wdata_o (ram_wdata_o),
    .ram_rdata_i (ram_rdata_i),
    .rdata_o     (mem_rdata)
  );

  assign bus_rdata_o = dp_sel  ? mem_rdata :
                       reg_sel ? {8'h00, reg_rdata} : 16'h0000;
endmodule

// File: tb/tb_rdma_port_engine.sv
`timescale 1ns/1ps
module tb_rdma_port_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [5:0]  rx_set = '0;
  logic        irq;
  logic [14:0] ram_addr;
  logic        ram_we;
  logic [1:0]  ram_be;
  logic [15:0] ram_wdata;
  logic [15:0] ram_rdata = '0;
  logic        probe = 1'b0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } exp_t;
  exp_t sb[$];
  logic [15:0] mem [int];

  always #2 clk = ~clk;

  rdma_port_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_set_i(rx_set), .irq_o(irq), .ram_addr_o(ram_addr), .ram_we_o(ram_we),
    .ram_be_o(ram_be), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  // synchronous RAM model, read-first
  always @(posedge clk) begin
    logic [15:0] cur;
    int a;
    a = int'(ram_addr);
    cur = mem.exists(a) ? mem[a] : 16'h0000;
    ram_rdata <= cur;
    if (ram_we) begin
      if (ram_be[0]) cur[7:0]  = ram_wdata[7:0];
      if (ram_be[1]) cur[15:8] = ram_wdata[15:8];
      mem[a] = cur;
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: scoreboard comparison while the strobe is applied
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if ((bus_rd || probe) && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        if (e.kind == 0) check(bus_rdata, e.exp, e.req);
        else             check({15'd0, irq}, e.exp, e.req);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; rx_set = '0; probe = 1'b0;
  endtask

  task automatic wr_rx(input logic [4:0] a, input logic [15:0] d, input logic [5:0] rx, input bit do_wr);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = do_wr; bus_rd = 1'b0; rx_set = rx;
    idle();
  endtask

  task automatic wreg(input logic [4:0] a, input logic [15:0] d);
    wr_rx(a, d, 6'd0, 1'b1);
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
    exp_t e;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
    e.kind = 0; e.exp = exp; e.req = req;
    sb.push_back(e);
    idle();
  endtask

  task automatic chk_irq(input logic v, input string req);
    exp_t e;
    @(negedge clk);
    probe = 1'b1;
    e.kind = 1; e.exp = {15'd0, v}; e.req = req;
    sb.push_back(e);
    idle();
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wreg(5'h08, {8'h00, a[7:0]});
    wreg(5'h09, {8'h00, a[15:8]});
  endtask

  task automatic set_cnt(input logic [15:0] c);
    wreg(5'h0A, {8'h00, c[7:0]});
    wreg(5'h0B, {8'h00, c[15:8]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R1 reset state
    rd(5'h00, 16'h0001, "R1");
    rd(5'h07, 16'h0080, "R1");
    rd(5'h08, 16'h0000, "R1");
    rd(5'h0B, 16'h0000, "R1");
    rd(5'h0F, 16'h0000, "R1");
    chk_irq(1'b0, "R1");
    // R12 status write never clears bit 7
    wreg(5'h07, 16'h00FF);
    rd(5'h07, 16'h0080, "R12");
    // R11 bit 7 does not drive irq
    wreg(5'h0F, 16'h00FF);
    chk_irq(1'b0, "R11");
    // R10 start clears bit 7
    wreg(5'h00, 16'h0022);
    rd(5'h07, 16'h0000, "R10");
    wreg(5'h0E, 16'h0000);
    wreg(5'h01, 16'h0040);
    wreg(5'h02, 16'h0042);
    // R2 pointer and count loads
    set_ptr(16'h40FE);
    set_cnt(16'h0003);
    rd(5'h08, 16'h00FE, "R2");
    rd(5'h09, 16'h0040, "R2");
    rd(5'h0A, 16'h0003, "R2");
    rd(5'h0B, 16'h0000, "R2");
    // R3 byte writes, R6 completion
    wreg(5'h10, 16'hAA11);
    rd(5'h08, 16'h00FF, "R3");
    rd(5'h0A, 16'h0002, "R3");
    wreg(5'h10, 16'h0022);
    wreg(5'h10, 16'h0033);
    rd(5'h08, 16'h0001, "R3");
    rd(5'h09, 16'h0041, "R3");
    rd(5'h0A, 16'h0000, "R6");
    rd(5'h07, 16'h0040, "R6");
    chk_irq(1'b1, "R11");
    wreg(5'h07, 16'h0040);
    rd(5'h07, 16'h0000, "R12");
    chk_irq(1'b0, "R11");
    // R7 write with zero count ignored
    wreg(5'h10, 16'h0099);
    rd(5'h08, 16'h0001, "R7");
    rd(5'h0A, 16'h0000, "R7");
    set_ptr(16'h4101);
    rd(5'h10, 16'h0000, "R7");
    // R9 byte read-back
    set_ptr(16'h40FE);
    set_cnt(16'h0003);
    rd(5'h10, 16'h0011, "R9");
    rd(5'h10, 16'h0022, "R9");
    rd(5'h10, 16'h0033, "R9");
    rd(5'h08, 16'h0001, "R9");
    rd(5'h0A, 16'h0000, "R9");
    // R4 word mode with R5 wrap
    wreg(5'h0E, 16'h0001);
    set_ptr(16'h41FC);
    set_cnt(16'h0006);
    wreg(5'h10, 16'hBEEF);
    rd(5'h0A, 16'h0004, "R4");
    wreg(5'h10, 16'hCAFE);
    rd(5'h08, 16'h0000, "R5");
    rd(5'h09, 16'h0040, "R5");
    wreg(5'h10, 16'h1234);
    rd(5'h08, 16'h0002, "R4");
    rd(5'h0A, 16'h0000, "R6");
    set_ptr(16'h41FD);
    set_cnt(16'h0004);
    rd(5'h10, 16'hBEEF, "R4");
    rd(5'h10, 16'hCAFE, "R4");
    rd(5'h08, 16'h0001, "R5");
    rd(5'h09, 16'h0042, "R5");
    set_ptr(16'h4000);
    set_cnt(16'h0002);
    rd(5'h10, 16'h1234, "R5");
    // R4 little-endian byte view
    wreg(5'h0E, 16'h0000);
    set_ptr(16'h41FC);
    set_cnt(16'h0002);
    rd(5'h10, 16'h00EF, "R4");
    rd(5'h10, 16'h00BE, "R4");
    // R8 memory windows
    set_ptr(16'h0100);
    set_cnt(16'h0001);
    wreg(5'h10, 16'h0055);
    check({15'd0, mem.exists(32'h80)}, 16'h0000, "R8");
    set_ptr(16'h0100);
    rd(5'h10, 16'h00FF, "R8");
    set_ptr(16'h001F);
    set_cnt(16'h0001);
    wreg(5'h10, 16'h00A5);
    set_ptr(16'h001F);
    rd(5'h10, 16'h00A5, "R8");
    set_ptr(16'h0020);
    rd(5'h10, 16'h00FF, "R8");
    wreg(5'h0E, 16'h0001);
    set_ptr(16'hBFFE);
    set_cnt(16'h0002);
    wreg(5'h10, 16'h5AA5);
    set_ptr(16'hBFFE);
    rd(5'h10, 16'h5AA5, "R8");
    set_ptr(16'hC000);
    rd(5'h10, 16'hFFFF, "R8");
    // R10 zero-length commands
    wreg(5'h07, 16'h007F);
    set_cnt(16'h0000);
    wreg(5'h00, 16'h0009);
    rd(5'h07, 16'h0000, "R10");
    wreg(5'h00, 16'h000A);
    rd(5'h00, 16'h000A, "R10");
    rd(5'h07, 16'h0040, "R10");
    wreg(5'h07, 16'h007F);
    set_cnt(16'h0005);
    wreg(5'h00, 16'h0012);
    rd(5'h07, 16'h0000, "R10");
    // R13 paging
    set_ptr(16'h4010);
    wreg(5'h00, 16'h0082);
    rd(5'h01, 16'h0040, "R13");
    rd(5'h02, 16'h0042, "R13");
    wreg(5'h08, 16'h0077);
    wreg(5'h0F, 16'h0000);
    wreg(5'h00, 16'h0002);
    rd(5'h08, 16'h0010, "R13");
    rd(5'h0F, 16'h00FF, "R13");
    rd(5'h01, 16'h0000, "R13");
    // R12 receive requests, R11 masking
    wreg(5'h0F, 16'h0001);
    wr_rx(5'h00, 16'h0000, 6'h05, 1'b0);
    rd(5'h07, 16'h0005, "R12");
    chk_irq(1'b1, "R11");
    wreg(5'h0F, 16'h0002);
    chk_irq(1'b0, "R11");
    wr_rx(5'h07, 16'h0001, 6'h01, 1'b1);
    rd(5'h07, 16'h0005, "R12");
    wreg(5'h07, 16'h0004);
    rd(5'h07, 16'h0001, "R12");
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule